// File: doc/BRIEF.md
# NOR flash command interpreter

This block is the control side of a parallel NOR-style flash device. It watches single-cycle bus writes (a strobe with an address and a data word) and turns multi-cycle command sequences into operations: single-word program, buffered program of up to a page of words, sector erase, suspend and resume of a running erase or program, and a reset command that leaves an aborted buffer load. There is no array storage. A countdown timer stands in for each embedded program or erase algorithm, and the block only tracks the device mode and drives a ready/busy output.

Two registers hold the state. The sequence state `seq` records how far the current command sequence has got: S_IDLE, S_UNL1 (first unlock seen), S_UNL2 (both unlocks seen), S_PGM_DATA, S_ERS_A, S_ERS_B, S_ERS_C (second unlock pair of an erase), S_BUF_CNT, S_BUF_LOAD and S_BUF_CONF. The device mode `mode` is one of M_READ, M_PGM, M_ERS, M_ES_READ (erase suspended, reads allowed), M_ES_PGM (program running while erase is suspended), M_PS (program suspended) and M_ABORT (buffer load failed). Sequences are accepted only in M_READ and M_ES_READ, and any unexpected address or data there sends `seq` back to S_IDLE. The mode transitions are: M_READ→M_PGM and M_ES_READ→M_ES_PGM on a program start; M_READ→M_ERS on an erase start; M_PGM→M_READ, M_ES_PGM→M_ES_READ and M_ERS→M_READ when the timer expires; M_ERS→M_ES_READ on suspend and back on resume; M_PGM→M_PS on suspend and back on resume; M_READ or M_ES_READ→M_ABORT on a failed buffer load; M_ABORT→M_READ or M_ES_READ on reset.

Unlock addresses are compared on address bits [10:0]. Command codes are compared on data bits [7:0]. With the defaults, sectors are 4096 words (address bits [15:12]) and buffer pages are 16 words (address bits [15:4]).

Top module: `flc_cmd_top`

## Requirements
- R1: After reset, `mode` is 0 (M_READ) and `rdy` is 1.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h, then any data at the target address start a word program. `mode` becomes 1 (M_PGM) and `rdy` stays low for exactly PGM_CYCLES cycles, after which `mode` returns to 0.
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at any address in the sector start a sector erase. `mode` becomes 2 (M_ERS) and `rdy` stays low for exactly ERS_CYCLES cycles, after which `mode` returns to 0.
- R4: A wrong address or data at any step of a sequence abandons it without starting an operation. The rest of the abandoned sequence then has no effect, and `mode` stays 0 with `rdy` high.
- R5: A reset write (F0h) in the middle of a sequence cancels it, and later writes that would have completed the sequence start nothing.
- R6: Buffered program runs as follows. First the unlock pair, then 25h at an address of the chosen page, then a count word holding the number of words minus one (0 to 15). Then that many data writes inside the page, then 29h in the same sector. This gives `mode` 1 and a low `rdy` for PGM_CYCLES cycles, for any size from 1 to 16 words.
- R7: Three events send `mode` to 6 (M_ABORT) with `rdy` high and no busy period: a data address outside the page during the buffer load, a count word of 16 or more, or a confirm word other than 29h.
- R8: An F0h write in M_ABORT returns `mode` to 0. If an erase was suspended, it returns `mode` to 3 (M_ES_READ) instead.
- R9: B0h written during an erase gives `mode` 3 with `rdy` high. A later 30h gives `mode` 2 again, and the busy cycles before and after the suspension add up to ERS_CYCLES.
- R10: In M_ES_READ, a word program to another sector gives `mode` 4 (M_ES_PGM) with `rdy` low for PGM_CYCLES cycles, then returns to 3, not 0.
- R11: In M_ES_READ, a program or buffer load aimed at the suspended sector is refused, and so is a new erase sequence. `mode` stays 3 with `rdy` high.
- R12: B0h written during a word program in M_PGM gives `mode` 5 (M_PS) with `rdy` high. 30h resumes to `mode` 1, and the total busy time is PGM_CYCLES.
- R13: While an operation is busy, every write other than a suspend is ignored, and the busy time is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe; the address and data are taken in any cycle where it is high |
| bus_addr | input | ADDR_W | Word address of the write cycle |
| bus_data | input | DATA_W | Data of the write cycle; bits [7:0] carry the command code |
| rdy | output | 1 | High when no embedded operation is running |
| mode | output | 3 | Current device mode (0 read, 1 program, 2 erase, 3 erase-suspend-read, 4 erase-suspend program, 5 program suspended, 6 aborted) |

## Verification
The hardest state to reach is a nested one: an erase suspended part-way, then a program to another sector completing inside the suspension, then a failed buffer load that must be cleared back to erase-suspend-read rather than plain read. The stimulus builds this chain in one directed run, then resumes the erase and checks that the busy cycles before and after the suspension still add up to the full erase time. Random stimulus chooses the suspend points, buffer sizes, page offsets, the position of an out-of-page word, and the step at which a sequence is corrupted.

// File: rtl/flc_pkg.sv
`timescale 1ns/1ps
package flc_pkg;

    typedef enum logic [2:0] {
        M_READ    = 3'd0,
        M_PGM     = 3'd1,
        M_ERS     = 3'd2,
        M_ES_READ = 3'd3,
        M_ES_PGM  = 3'd4,
        M_PS      = 3'd5,
        M_ABORT   = 3'd6
    } mode_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UNL1,
        S_UNL2,
        S_PGM_DATA,
        S_ERS_A,
        S_ERS_B,
        S_ERS_C,
        S_BUF_CNT,
        S_BUF_LOAD,
        S_BUF_CONF
    } seq_e;

    localparam logic [7:0]  K_KEY1     = 8'hAA;
    localparam logic [7:0]  K_KEY2     = 8'h55;
    localparam logic [7:0]  K_WORD_PGM = 8'hA0;
    localparam logic [7:0]  K_ERS_ARM  = 8'h80;
    localparam logic [7:0]  K_ERS_GO   = 8'h30;
    localparam logic [7:0]  K_BUF_OPEN = 8'h25;
    localparam logic [7:0]  K_BUF_GO   = 8'h29;
    localparam logic [7:0]  K_HOLD     = 8'hB0;
    localparam logic [7:0]  K_CONTINUE = 8'h30;
    localparam logic [7:0]  K_CLEAR    = 8'hF0;

    localparam int          KEY_AW     = 11;
    localparam logic [10:0] KEY_ADDR1  = 11'h555;
    localparam logic [10:0] KEY_ADDR2  = 11'h2AA;

endpackage

// File: rtl/flc_timer.sv
`timescale 1ns/1ps
module flc_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= CW'(CYCLES);
        end else if (run && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign expire = run && (left_q == CW'(1));
endmodule

// File: rtl/flc_bufpage.sv
`timescale 1ns/1ps
module flc_bufpage #(
    parameter int ADDR_W   = 16,
    parameter int PAGE_W   = 4,
    parameter int SECT_LSB = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     arm,
    input  logic                     set_cnt,
    input  logic                     take,
    input  logic [ADDR_W-PAGE_W-1:0] page_in,
    input  logic [PAGE_W-1:0]        cnt_in,
    output logic                     in_page,
    output logic                     in_sector,
    output logic                     last
);
    localparam int PG_W = ADDR_W - PAGE_W;
    localparam int SOFF = SECT_LSB - PAGE_W;

    logic [PG_W-1:0]   page_q;
    logic [PAGE_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            rem_q  <= '0;
        end else begin
            if (arm) begin
                page_q <= page_in;
            end
            if (set_cnt) begin
                rem_q <= cnt_in;
            end else if (take && rem_q != '0) begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    assign in_page   = (page_in == page_q);
    assign in_sector = (page_in[PG_W-1:SOFF] == page_q[PG_W-1:SOFF]);
    assign last      = (rem_q == '0);
endmodule

// File: rtl/flc_cmd_top.sv
`timescale 1ns/1ps
module flc_cmd_top
    import flc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int PAGE_W     = 4,
    parameter int SECT_LSB   = 12,
    parameter int PGM_CYCLES = 10,
    parameter int ERS_CYCLES = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              rdy,
    output logic [2:0]        mode
);
    localparam int BUF_MAX = 1 << PAGE_W;
    localparam int SC_W    = ADDR_W - SECT_LSB;

    seq_e            seq_q, seq_d;
    mode_e           mode_q, mode_d;
    logic            esusp_q, esusp_d;
    logic [SC_W-1:0] esect_q, esect_d;

    logic pgm_load, ers_load, pgm_exp, ers_exp;
    logic buf_arm, buf_set, buf_take;
    logic in_page, in_sector, buf_last;

    logic [7:0]      cmd;
    logic            at_key1, at_key2, hits_esect, cnt_fits;
    logic [SC_W-1:0] cur_sect;

    assign cmd        = bus_data[7:0];
    assign at_key1    = (bus_addr[KEY_AW-1:0] == KEY_ADDR1);
    assign at_key2    = (bus_addr[KEY_AW-1:0] == KEY_ADDR2);
    assign cur_sect   = bus_addr[ADDR_W-1:SECT_LSB];
    assign hits_esect = esusp_q && (cur_sect == esect_q);
    assign cnt_fits   = (bus_data < DATA_W'(BUF_MAX));

    flc_timer #(.CYCLES(PGM_CYCLES)) u_pgm_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (pgm_load),
        .run    (mode_q == M_PGM || mode_q == M_ES_PGM),
        .expire (pgm_exp)
    );

    flc_timer #(.CYCLES(ERS_CYCLES)) u_ers_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ers_load),
        .run    (mode_q == M_ERS),
        .expire (ers_exp)
    );

    flc_bufpage #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_LSB(SECT_LSB)) u_bufpage (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (buf_arm),
        .set_cnt   (buf_set),
        .take      (buf_take),
        .page_in   (bus_addr[ADDR_W-1:PAGE_W]),
        .cnt_in    (bus_data[PAGE_W-1:0]),
        .in_page   (in_page),
        .in_sector (in_sector),
        .last      (buf_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q   <= S_IDLE;
            mode_q  <= M_READ;
            esusp_q <= 1'b0;
            esect_q <= '0;
        end else begin
            seq_q   <= seq_d;
            mode_q  <= mode_d;
            esusp_q <= esusp_d;
            esect_q <= esect_d;
        end
    end

    // Next state
    always_comb begin
        seq_d    = seq_q;
        mode_d   = mode_q;
        esusp_d  = esusp_q;
        esect_d  = esect_q;
        pgm_load = 1'b0;
        ers_load = 1'b0;
        buf_arm  = 1'b0;
        buf_set  = 1'b0;
        buf_take = 1'b0;
        unique case (mode_q)
            M_PGM: begin
                if (pgm_exp)                         mode_d = M_READ;
                else if (bus_we && cmd == K_HOLD)    mode_d = M_PS;
            end
            M_ES_PGM: begin
                if (pgm_exp)                         mode_d = M_ES_READ;
            end
            M_ERS: begin
                if (ers_exp) begin
                    mode_d = M_READ;
                end else if (bus_we && cmd == K_HOLD) begin
                    mode_d  = M_ES_READ;
                    esusp_d = 1'b1;
                end
            end
            M_PS: begin
                if (bus_we && cmd == K_CONTINUE)     mode_d = M_PGM;
            end
            M_ABORT: begin
                if (bus_we && cmd == K_CLEAR)        mode_d = esusp_q ? M_ES_READ : M_READ;
            end
            M_READ, M_ES_READ: begin
                if (bus_we) begin
                    seq_d = S_IDLE;
                    unique case (seq_q)
                        S_IDLE: begin
                            if (cmd == K_KEY1 && at_key1) begin
                                seq_d = S_UNL1;
                            end else if (mode_q == M_ES_READ && cmd == K_CONTINUE) begin
                                mode_d  = M_ERS;
                                esusp_d = 1'b0;
                            end
                        end
                        S_UNL1: begin
                            if (cmd == K_KEY2 && at_key2) seq_d = S_UNL2;
                        end
                        S_UNL2: begin
                            if (at_key1 && cmd == K_WORD_PGM) begin
                                seq_d = S_PGM_DATA;
                            end else if (at_key1 && cmd == K_ERS_ARM && mode_q == M_READ) begin
                                seq_d = S_ERS_A;
                            end else if (cmd == K_BUF_OPEN && !hits_esect) begin
                                seq_d   = S_BUF_CNT;
                                buf_arm = 1'b1;
                            end
                        end
                        S_PGM_DATA: begin
                            if (!hits_esect) begin
                                pgm_load = 1'b1;
                                mode_d   = (mode_q == M_ES_READ) ? M_ES_PGM : M_PGM;
                            end
                        end
                        S_ERS_A: begin
                            if (cmd == K_KEY1 && at_key1) seq_d = S_ERS_B;
                        end
                        S_ERS_B: begin
                            if (cmd == K_KEY2 && at_key2) seq_d = S_ERS_C;
                        end
                        S_ERS_C: begin
                            if (cmd == K_ERS_GO) begin
                                ers_load = 1'b1;
                                mode_d   = M_ERS;
                                esect_d  = cur_sect;
                            end
                        end
                        S_BUF_CNT: begin
                            if (cnt_fits) begin
                                buf_set = 1'b1;
                                seq_d   = S_BUF_LOAD;
                            end else begin
                                mode_d = M_ABORT;
                            end
                        end
                        S_BUF_LOAD: begin
                            if (!in_page) begin
                                mode_d = M_ABORT;
                            end else begin
                                buf_take = 1'b1;
                                seq_d    = buf_last ? S_BUF_CONF : S_BUF_LOAD;
                            end
                        end
                        S_BUF_CONF: begin
                            if (cmd == K_BUF_GO && in_sector) begin
                                pgm_load = 1'b1;
                                mode_d   = (mode_q == M_ES_READ) ? M_ES_PGM : M_PGM;
                            end else begin
                                mode_d = M_ABORT;
                            end
                        end
                        default: seq_d = S_IDLE;
                    endcase
                end
            end
            default: mode_d = M_READ;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (mode_q)
            M_PGM, M_ERS, M_ES_PGM: rdy = 1'b0;
            default:                rdy = 1'b1;
        endcase
        mode = mode_q;
    end
endmodule

// File: rtl/flc_chk.sv
`timescale 1ns/1ps
module flc_chk
    import flc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic [7:0] cmd,
    input logic       rdy,
    input logic [2:0] mode
);
    AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> $past(bus_we)); // R2

    AST_ABORT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_ABORT && $past(mode) != M_ABORT) |-> ($past(mode) == M_READ || $past(mode) == M_ES_READ)); // R7

    AST_ABORT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == M_ABORT && mode != M_ABORT) |-> ($past(bus_we) && $past(cmd) == K_CLEAR)); // R8

    AST_ERASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == M_ERS && mode == M_ES_READ) |-> ($past(bus_we) && $past(cmd) == K_HOLD)); // R9

    AST_ES_PGM_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == M_ES_PGM && mode != M_ES_PGM) |-> (mode == M_ES_READ)); // R10

    AST_NO_ERASE_IN_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == M_ES_READ && mode == M_ERS) |-> ($past(bus_we) && $past(cmd) == K_CONTINUE)); // R11

    AST_PGM_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_PS && $past(mode) != M_PS) |-> ($past(mode) == M_PGM)); // R12
endmodule

bind flc_cmd_top flc_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_we (bus_we),
    .cmd    (bus_data[7:0]),
    .rdy    (rdy),
    .mode   (mode)
);

// File: tb/flc_cmd_top_tb.sv
`timescale 1ns/1ps
module flc_cmd_top_tb;
    localparam int PGM = 10;
    localparam int ERS = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] data = '0;
    logic        rdy;
    logic [2:0]  mode;
    int          n_chk = 0;
    int          n_fail = 0;
    int          busy_cnt = 0;

    always #2.5 clk = ~clk;

    flc_cmd_top #(.PGM_CYCLES(PGM), .ERS_CYCLES(ERS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
        .bus_data(data), .rdy(rdy), .mode(mode)
    );

    always @(posedge clk) if (rst_n && !rdy) busy_cnt <= busy_cnt + 1;

    function automatic int mode_after_clear(input bit susp);
        return susp ? 3 : 0;
    endfunction

    function automatic logic [15:0] page_addr(input logic [15:0] base, input int off);
        return {base[15:4], 4'(off)};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        we = 1'b1; addr = a; data = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic unlock();
        wr(16'h0555, 16'h00AA);
        wr(16'h02AA, 16'h0055);
    endtask

    task automatic prog(input logic [15:0] a, input logic [15:0] d);
        unlock();
        wr(16'h0555, 16'h00A0);
        wr(a, d);
    endtask

    task automatic erase(input logic [15:0] a);
        unlock();
        wr(16'h0555, 16'h0080);
        unlock();
        wr(a, 16'h0030);
    endtask

    task automatic wait_rdy();
        int g = 0;
        while (!rdy && g < 5000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic buf_prog(input logic [15:0] base, input int n, input int bad, input logic [7:0] conf);
        unlock();
        wr(base, 16'h0025);
        wr(base, 16'(n - 1));
        for (int i = 0; i < n; i++) begin
            logic [15:0] a;
            a = page_addr(base, int'($urandom % 16));
            if (i == bad) begin
                wr(a ^ 16'h0010, 16'($urandom));
                return;
            end
            wr(a, 16'($urandom));
        end
        wr(base, {8'h00, conf});
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdy", rdy, 1);
        check("R1 mode", mode, 0);

        // word program
        busy_cnt = 0;
        prog(16'h0100, 16'h1234);
        check("R2 mode busy", mode, 1);
        check("R2 rdy low", rdy, 0);
        wait_rdy();
        check("R2 busy cycles", busy_cnt, PGM);
        check("R2 mode after", mode, 0);

        // sector erase
        busy_cnt = 0;
        erase(16'h3000);
        check("R3 mode busy", mode, 2);
        wait_rdy();
        check("R3 busy cycles", busy_cnt, ERS);
        check("R3 mode after", mode, 0);

        // corrupted sequences
        for (int k = 0; k < 6; k++) begin
            int step = int'($urandom % 3);
            busy_cnt = 0;
            if (step == 0) wr(16'h0554, 16'h00AA); else wr(16'h0555, 16'h00AA);
            if (step == 1) wr(16'h02AA, 16'h0056); else wr(16'h02AA, 16'h0055);
            if (step == 2) wr(16'h0555, 16'h0077); else wr(16'h0555, 16'h00A0);
            wr(16'h0010, 16'h1234);
            repeat (2) @(negedge clk);
            check("R4 no start mode", mode, 0);
            check("R4 no busy", busy_cnt, 0);
        end
        busy_cnt = 0;
        prog(16'h0020, 16'h00FF);
        wait_rdy();
        check("R4 fresh sequence works", busy_cnt, PGM);

        // reset mid-sequence
        busy_cnt = 0;
        unlock();
        wr(16'h0555, 16'h0080);
        wr(16'h0000, 16'h00F0);
        wr(16'h02AA, 16'h0055);
        wr(16'h3000, 16'h0030);
        unlock();
        wr(16'h0000, 16'h00F0);
        wr(16'h0040, 16'h0011);
        repeat (2) @(negedge clk);
        check("R5 cancelled mode", mode, 0);
        check("R5 cancelled busy", busy_cnt, 0);

        // buffered program: directed edges and random sizes
        for (int k = 0; k < 6; k++) begin
            int n = (k == 0) ? 1 : (k == 1) ? 16 : 1 + int'($urandom % 16);
            logic [15:0] base = 16'($urandom) & 16'hFFF0;
            busy_cnt = 0;
            buf_prog(base, n, -1, 8'h29);
            check("R6 buffer busy mode", mode, 1);
            wait_rdy();
            check("R6 buffer busy cycles", busy_cnt, PGM);
            check("R6 buffer done", mode, 0);
        end

        // aborts
        begin
            int bad = int'($urandom % 8);
            buf_prog(16'h2240, 8, bad, 8'h29);
            check("R7 out-of-page abort", mode, 6);
            check("R7 abort rdy", rdy, 1);
            wr(16'h0000, 16'h00F0);
            check("R8 clear to read", mode, mode_after_clear(1'b0));
        end
        unlock();
        wr(16'h1100, 16'h0025);
        wr(16'h1100, 16'h0010);
        check("R7 count too large", mode, 6);
        wr(16'h0000, 16'h00F0);
        check("R8 clear after count", mode, 0);
        buf_prog(16'h1100, 3, -1, 8'h28);
        check("R7 bad confirm", mode, 6);
        wr(16'h0000, 16'h00F0);
        check("R8 clear after confirm", mode, 0);

        // writes ignored while busy
        busy_cnt = 0;
        prog(16'h0200, 16'h5555);
        wr(16'h0000, 16'h00F0);
        wr(16'h0000, 16'h0030);
        wr(16'h0555, 16'h00AA);
        check("R13 still busy", mode, 1);
        wait_rdy();
        check("R13 busy cycles", busy_cnt, PGM);

        // program suspend
        busy_cnt = 0;
        prog(16'h0300, 16'h0001);
        repeat (3) @(negedge clk);
        wr(16'h0000, 16'h00B0);
        check("R12 suspended mode", mode, 5);
        check("R12 suspended rdy", rdy, 1);
        repeat (4) @(negedge clk);
        wr(16'h0000, 16'h0030);
        check("R12 resumed mode", mode, 1);
        wait_rdy();
        check("R12 total busy", busy_cnt, PGM);

        // erase suspend at random points
        for (int k = 0; k < 3; k++) begin
            int a = int'($urandom % (ERS - 4));
            busy_cnt = 0;
            erase(16'h4000);
            repeat (a) @(negedge clk);
            wr(16'h0000, 16'h00B0);
            check("R9 suspended mode", mode, 3);
            check("R9 suspended rdy", rdy, 1);
            repeat (5) @(negedge clk);
            wr(16'h0000, 16'h0030);
            check("R9 resumed mode", mode, 2);
            wait_rdy();
            check("R9 total busy", busy_cnt, ERS);
        end

        // nested: program and abort inside an erase suspension
        erase(16'h3000);
        repeat (2) @(negedge clk);
        wr(16'h0000, 16'h00B0);
        busy_cnt = 0;
        prog(16'h0100, 16'h0042);
        check("R10 es program mode", mode, 4);
        check("R10 es program rdy", rdy, 0);
        wait_rdy();
        check("R10 es program busy", busy_cnt, PGM);
        check("R10 back to es read", mode, 3);
        prog(16'h3010, 16'h0042);
        check("R11 same sector refused", mode, 3);
        check("R11 same sector rdy", rdy, 1);
        unlock();
        wr(16'h3000, 16'h0025);
        check("R11 buffer same sector refused", mode, 3);
        unlock();
        wr(16'h0555, 16'h0080);
        unlock();
        wr(16'h5000, 16'h0030);
        check("R11 erase refused", mode, 3);
        buf_prog(16'h1000, 4, 2, 8'h29);
        check("R7 abort in suspend", mode, 6);
        wr(16'h0000, 16'h00F0);
        check("R8 clear to es read", mode, mode_after_clear(1'b1));
        wr(16'h0000, 16'h0030);
        check("R9 resume after nest", mode, 2);
        wait_rdy();
        check("R9 erase done", mode, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule